// File: doc/BRIEF.md
# Host Bridge Control Register File

This block holds the 32-bit control registers of a host bridge: power-on and general configuration, I/O and memory setup, address-map control, GPIO, interrupt controller setup, four mailboxes, cache control and timing words. The registers sit in a 0x70-byte window at word-aligned offsets 0x00 to 0x6C. Software reaches them over a simple bus of single-cycle word reads and writes. Read data comes back registered, one cycle after the read strobe. The bus has no stall and no back-pressure, so every strobe completes in the cycle it is presented. Only whole 32-bit words are transferred.

The interrupt-enable word cannot be written directly. Bits are turned on through a set alias and turned off through a clear alias. The live enable vector drives a dedicated output. When software takes bit 2 of the general configuration word from 0 to 1, the block issues a one-cycle system reset request. The values stored in the other registers are passed on unchanged; the logic they configure lives elsewhere.

Top module: `bridge_ctrl_regs`

## Requirements
- R1: After reset the registers read as follows: 0x00 = 0x00000C40, 0x04 = 0x00001384, 0x08 = 0x2BFF8010, 0x0C = 0x255E0091, 0x10 = 0x00006140, 0x1C = 0x000001FF, 0x20 = 0x000001FF, 0x68 = 0x00000008, 0x6C = 0x10000000. Every other offset reads zero.
- R2: Every word offset from 0x00 to 0x6C other than 0x38 and 0x3C is plain storage. A write to it stores the full 32-bit value.
- R3: A write to 0x30 (enable-set) stores the value at 0x30 and ORs it into the enable word at 0x38.
- R4: A write to 0x34 (enable-clear) stores the value at 0x34 and clears, in the enable word at 0x38, every bit that is 1 in the written value.
- R5: Offsets 0x38 (enable) and 0x3C (interrupt status) are read-only and ignore writes. 0x3C always reads zero.
- R6: A write to 0x04 with bit 2 set, while the stored bit 2 is 0, stores the value and drives `rst_req` high for exactly the one cycle after the write edge.
- R7: A write to 0x04 while the stored bit 2 is already 1, or with bit 2 clear, produces no reset request.
- R8: A write to an offset at or above 0x70, or to an address whose two low bits are not zero, changes nothing. A read of such an address returns zero.
- R9: `rdata` is loaded at the clock edge that samples `rd_en` and holds its value while `rd_en` is low. A read and a write to the same word in the same cycle return the value held before the write.
- R10: `irq_en` always equals the enable word at 0x38.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the addressed word |
| rd_en | input | 1 | Read strobe for the addressed word |
| addr | input | 8 | Byte address within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_en | output | 32 | Live interrupt-enable vector |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A write takes effect at the rising edge that samples it. A read returns its data at the same edge, so the value is visible from the next falling edge on. `rst_req` is high from the edge that takes the write until the following edge. The bench drives every strobe on a falling edge and removes it on the next falling edge. It samples `rdata` and `rst_req` at that second falling edge, and it checks `rst_req` again one falling edge later to confirm that the pulse has ended. Each vector in the table is a write followed by a read, so the effect of every set, clear, read-only or dropped write is observed through the normal read path.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 28;          // 0x70 bytes of 32-bit words
  localparam int IDX_GEN  = 1;           // general config, holds the reset trigger
  localparam int IDX_ENSET = 12;         // 0x30
  localparam int IDX_ENCLR = 13;         // 0x34
  localparam int IDX_EN    = 14;         // 0x38, read-only
  localparam int IDX_ISR   = 15;         // 0x3C, read-only
  localparam int GEN_RST_BIT = 2;

  function automatic logic [DATA_W-1:0] reg_reset(input int idx);
    case (idx)
      0:       return 32'h0000_0C40;
      1:       return 32'h0000_1384;
      2:       return 32'h2BFF_8010;
      3:       return 32'h255E_0091;
      4:       return 32'h0000_6140;
      7:       return 32'h0000_01FF;
      8:       return 32'h0000_01FF;
      26:      return 32'h0000_0008;
      27:      return 32'h1000_0000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/brc_decode.sv
module brc_decode #(
  parameter int ADDR_W = 8,
  parameter int NREGS  = brc_pkg::NUM_REGS,
  localparam int WORD_W = ADDR_W - 2,
  localparam int IDX_W  = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [NREGS-1:0]  wr_sel
);
  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];
  assign hit  = (addr[1:0] == 2'b00) && (int'(word) < NREGS);
  assign idx  = word[IDX_W-1:0];

  for (genvar i = 0; i < NREGS; i++) begin : g_sel
    assign wr_sel[i] = wr_en && hit && (word == WORD_W'(i));
  end

  // R8: an address outside the window or off word alignment selects nothing
  assert_miss_no_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit) |-> (wr_sel == '0));
  assert_sel_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
endmodule

// File: rtl/brc_enable.sv
module brc_enable #(
  parameter int W = brc_pkg::DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_wr,
  input  logic         clr_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (set_wr) en_q <= en_q | wdata;
    else if (clr_wr) en_q <= en_q & ~wdata;
  end

  assert_set_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> (en_q == ($past(en_q) | $past(wdata))));
  assert_clr_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (en_q == ($past(en_q) & ~$past(wdata))));
  // R5: nothing but the two aliases moves the enable word
  assert_en_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_wr && !clr_wr) |=> $stable(en_q));
endmodule

// File: rtl/brc_rstreq.sv
module brc_rstreq (
  input  logic clk,
  input  logic rst_n,
  input  logic gen_wr,
  input  logic old_bit,
  input  logic new_bit,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= gen_wr && new_bit && !old_bit;
  end

  assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  assert_req_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ($past(gen_wr) && $past(new_bit) && !$past(old_bit)));
  assert_no_req_when_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_wr && old_bit) |=> !req);
endmodule

// File: rtl/bridge_ctrl_regs.sv
module bridge_ctrl_regs #(
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [brc_pkg::DATA_W-1:0]  wdata,
  output logic [brc_pkg::DATA_W-1:0]  rdata,
  output logic [brc_pkg::DATA_W-1:0]  irq_en,
  output logic                        rst_req
);
  import brc_pkg::*;
  localparam int IDX_W = $clog2(NUM_REGS);

  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [NUM_REGS-1:0] wr_sel;
  logic [DATA_W-1:0] view [NUM_REGS];
  logic [DATA_W-1:0] en_q;

  brc_decode #(.ADDR_W(ADDR_W), .NREGS(NUM_REGS)) u_decode (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .hit(hit), .idx(idx), .wr_sel(wr_sel));

  brc_enable #(.W(DATA_W)) u_enable (
    .clk(clk), .rst_n(rst_n), .set_wr(wr_sel[IDX_ENSET]),
    .clr_wr(wr_sel[IDX_ENCLR]), .wdata(wdata), .en_q(en_q));

  brc_rstreq u_rstreq (
    .clk(clk), .rst_n(rst_n), .gen_wr(wr_sel[IDX_GEN]),
    .old_bit(view[IDX_GEN][GEN_RST_BIT]), .new_bit(wdata[GEN_RST_BIT]),
    .req(rst_req));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == IDX_EN) begin : g_en
      assign view[i] = en_q;
    end else if (i == IDX_ISR) begin : g_isr
      assign view[i] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= reg_reset(i);
        else if (wr_sel[i]) q <= wdata;
      end
      assign view[i] = q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= hit ? view[idx] : '0;
  end

  assign irq_en = en_q;

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |=> $stable(rdata));
  assert_miss_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (rdata == '0));
  assert_ro_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && (idx == IDX_W'(IDX_EN))) |=> $stable(irq_en));
endmodule

// File: tb/bridge_ctrl_regs_bench.sv
module bridge_ctrl_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  // write wa<=wd, then read ra and expect exp; req is the requirement number
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 32'hDEAD_BEEF, 8'h00, 32'hDEAD_BEEF, 8'd2},  // R2
    '{8'h6C, 32'h1234_5678, 8'h6C, 32'h1234_5678, 8'd2},  // R2
    '{8'h30, 32'h0000_F0F0, 8'h38, 32'h0000_F0F0, 8'd3},  // R3
    '{8'h30, 32'h0000_000F, 8'h38, 32'h0000_F0FF, 8'd3},  // R3
    '{8'h34, 32'h0000_00F0, 8'h38, 32'h0000_F00F, 8'd4},  // R4
    '{8'h34, 32'h1000_0001, 8'h38, 32'h0000_F00E, 8'd4},  // R4
    '{8'h30, 32'h0000_0100, 8'h34, 32'h1000_0001, 8'd4},  // R4 stored value
    '{8'h38, 32'hFFFF_FFFF, 8'h38, 32'h0000_F10E, 8'd5},  // R5
    '{8'h3C, 32'hFFFF_FFFF, 8'h3C, 32'h0000_0000, 8'd5},  // R5
    '{8'h70, 32'hAAAA_AAAA, 8'h70, 32'h0000_0000, 8'd8},  // R8
    '{8'h41, 32'h5555_5555, 8'h40, 32'h0000_0000, 8'd8},  // R8
    '{8'h48, 32'h0BAD_F00D, 8'h48, 32'h0BAD_F00D, 8'd2}   // R2
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, irq_en;
  logic        rst_req;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  bridge_ctrl_regs u_bridge_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_en(irq_en), .rst_req(rst_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset defaults
    check("R1 rst_req", {31'd0, rst_req}, 32'd0);
    check("R10 irq_en after reset", irq_en, 32'd0);
    do_read(8'h00, d); check("R1 0x00", d, 32'h0000_0C40);
    do_read(8'h04, d); check("R1 0x04", d, 32'h0000_1384);
    do_read(8'h08, d); check("R1 0x08", d, 32'h2BFF_8010);
    do_read(8'h0C, d); check("R1 0x0C", d, 32'h255E_0091);
    do_read(8'h10, d); check("R1 0x10", d, 32'h0000_6140);
    do_read(8'h1C, d); check("R1 0x1C", d, 32'h0000_01FF);
    do_read(8'h20, d); check("R1 0x20", d, 32'h0000_01FF);
    do_read(8'h68, d); check("R1 0x68", d, 32'h0000_0008);
    do_read(8'h6C, d); check("R1 0x6C", d, 32'h1000_0000);
    do_read(8'h24, d); check("R1 0x24", d, 32'h0000_0000);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      do_write(VECS[i].wa, VECS[i].wd);
      do_read(VECS[i].ra, d);
      tag = $sformatf("R%0d vector %0d", VECS[i].req, i);
      check(tag, d, VECS[i].exp);
    end
    check("R10 irq_en mirrors enable", irq_en, 32'h0000_F10E);
    do_read(8'h42, d); check("R8 misaligned read", d, 32'h0);

    // R7: clearing bit 2 gives no request, value stored
    do_write(8'h04, 32'h0000_1380);
    check("R7 no req on clear", {31'd0, rst_req}, 32'd0);
    do_read(8'h04, d); check("R7 stored 0x04", d, 32'h0000_1380);
    // R6: 0 -> 1 on bit 2
    do_write(8'h04, 32'h0000_1384);
    check("R6 req pulse", {31'd0, rst_req}, 32'd1);
    @(negedge clk);
    check("R6 req one cycle", {31'd0, rst_req}, 32'd0);
    do_read(8'h04, d); check("R6 stored 0x04", d, 32'h0000_1384);
    // R7: bit already 1
    do_write(8'h04, 32'hFFFF_FFFF);
    check("R7 no req when set", {31'd0, rst_req}, 32'd0);

    // R9: read and write same word in one cycle return the old value
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 8'h08; wdata = 32'hCAFE_0001;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check("R9 read before write", rdata, 32'h2BFF_8010);
    do_write(8'h0C, 32'h7777_7777);
    check("R9 rdata holds", rdata, 32'h2BFF_8010);
    do_read(8'h08, d); check("R9 new value", d, 32'hCAFE_0001);

    finish_run();
  end
endmodule